// File: doc/BRIEF.md
# Clock Synthesizer Reprogramming Sequencer

This block changes the divider settings of one on-chip clock synthesizer without ever exposing downstream logic to an unstable clock. A request carries three divider values: a reference divider (NR), a feedback multiplier (NF) and a post divider (NO). The block first checks that the triple is legal. It then runs a fixed handshake. The clock is moved onto the crystal bypass and the synthesizer is held in reset. The divider fields are loaded. The block waits a settle time, releases reset, and waits for the lock indication before moving the clock back onto the synthesizer.

The analog loop is outside this block. The block only drives the mode select, the synthesizer reset and the divider fields, and samples a lock input. It reports `done` when a sequence finishes, and `err` when a triple is rejected or lock never arrives.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `mode_normal`, `pll_rst`, `busy`, `done`, `err` and all four divider fields are 0, which means the clock runs from the crystal bypass.
- R2: An accepted `start` drives `mode_normal` to 0 and `busy` to 1 on the same clock edge. `pll_rst` rises one cycle later and is never 1 while `mode_normal` is 1.
- R3: One cycle after `pll_rst` rises, the fields load as follows: `nr_field`=NR-1, `nf_field`=NF-1, `no_field`=NO-1 and `bw_field`=floor(NF/2)-1. The fields change only while `pll_rst` is 1.
- R4: After the fields are loaded, `pll_rst` stays 1 for exactly SETTLE_US*CYCLES_PER_US cycles and then falls.
- R5: After the release, `mode_normal` returns to 1 only on the edge after `lock_in` is sampled high. On that same edge `done` pulses for one cycle and `busy` falls.
- R6: A triple is legal only when all of the following hold. NR, NF and NO are nonzero. NO is 1 or even. The VCO rate 24000*NF/NR kHz lies in [440000, 2200000] kHz, with both ends included. The output rate VCO/NO lies in [27500, 2200000] kHz.
- R7: An illegal triple gives a one-cycle `err` pulse on the edge that samples `start`. It leaves `mode_normal`, `pll_rst`, `busy` and the fields unchanged.
- R8: A `start` that arrives while `busy` is 1 is ignored. This includes a start sampled on the edge that ends a sequence. An ignored start changes neither the fields nor the sequence length.
- R9: If `lock_in` has not been seen LOCK_TIMEOUT cycles after the release, `err` pulses for one cycle and `busy` falls. `mode_normal` stays 0 and `done` does not pulse.
- R10: `done` and `err` never pulse in the same cycle, and `busy` is 0 whenever either of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to reprogram, sampled while idle |
| nr_in | input | NR_W | Reference divider NR |
| nf_in | input | NF_W | Feedback multiplier NF |
| no_in | input | NO_W | Post divider NO |
| lock_in | input | 1 | Lock status from the synthesizer |
| mode_normal | output | 1 | 1 selects the synthesizer output, 0 selects the crystal bypass |
| pll_rst | output | 1 | Synthesizer reset |
| nr_field | output | NR_W | Reference divider field, NR-1 |
| nf_field | output | NF_W | Feedback field, NF-1 |
| no_field | output | NO_W | Post divider field, NO-1 |
| bw_field | output | NF_W-1 | Bandwidth field, floor(NF/2)-1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | One-cycle pulse on an illegal triple or a lock timeout |

## Verification
Two events can fall into one cycle: the lock that ends a sequence and a new start request. The bench raises `start` with a different triple in the very cycle the design first samples `lock_in` high. The expected result is a single `done` with `busy` low afterwards, the fields still holding the first triple, and no second reset. A start pulsed during the settle wait is judged the same way: the settle length stays unchanged and the fields stay unchanged.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   localparam int unsigned VCO_MIN_KHZ = 440000;
   localparam int unsigned VCO_MAX_KHZ = 2200000;
   localparam int unsigned OUT_MIN_KHZ = 27500;
   localparam int unsigned OUT_MAX_KHZ = 2200000;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_HOLD,
      SQ_LOAD,
      SQ_SETTLE,
      SQ_POLL
   } seq_state_t;
endpackage

// File: rtl/pll_param_check.sv
module pll_param_check #(
   parameter int NR_W    = 6,
   parameter int NF_W    = 13,
   parameter int NO_W    = 4,
   parameter int REF_KHZ = 24000
) (
   input  logic [NR_W-1:0] nr,
   input  logic [NF_W-1:0] nf,
   input  logic [NO_W-1:0] no,
   output logic            legal
);
   import pll_seq_pkg::*;
   localparam int PW = 48;

   logic [PW-1:0] vco_num, vco_lo, vco_hi, out_lo, out_hi, nr_no;
   logic          nonzero, no_ok;

   always_comb begin
      nr_no   = PW'(nr) * PW'(no);
      vco_num = PW'(REF_KHZ) * PW'(nf);
      vco_lo  = PW'(VCO_MIN_KHZ) * PW'(nr);
      vco_hi  = PW'(VCO_MAX_KHZ) * PW'(nr);
      out_lo  = PW'(OUT_MIN_KHZ) * nr_no;
      out_hi  = PW'(OUT_MAX_KHZ) * nr_no;
      nonzero = (nr != '0) && (nf != '0) && (no != '0);
      no_ok   = (no == NO_W'(1)) || !no[0];
      legal   = nonzero && no_ok &&
                (vco_num >= vco_lo) && (vco_num <= vco_hi) &&
                (vco_num >= out_lo) && (vco_num <= out_hi);
   end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (count != {W{1'b1}}) count <= count + W'(1);
   end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
   parameter int NR_W          = 6,
   parameter int NF_W          = 13,
   parameter int NO_W          = 4,
   parameter int REF_KHZ       = 24000,
   parameter int CYCLES_PER_US = 250,
   parameter int SETTLE_US     = 10,
   parameter int LOCK_TIMEOUT  = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NR_W-1:0]   nr_in,
   input  logic [NF_W-1:0]   nf_in,
   input  logic [NO_W-1:0]   no_in,
   input  logic              lock_in,
   output logic              mode_normal,
   output logic              pll_rst,
   output logic [NR_W-1:0]   nr_field,
   output logic [NF_W-1:0]   nf_field,
   output logic [NO_W-1:0]   no_field,
   output logic [NF_W-2:0]   bw_field,
   output logic              busy,
   output logic              done,
   output logic              err
);
   import pll_seq_pkg::*;

   localparam int SETTLE_CYC = SETTLE_US * CYCLES_PER_US;
   localparam int MAX_WAIT   = (SETTLE_CYC > LOCK_TIMEOUT) ? SETTLE_CYC : LOCK_TIMEOUT;
   localparam int TW         = $clog2(MAX_WAIT + 1);
   localparam int BW_W       = NF_W - 1;

   generate
      if (CYCLES_PER_US < 1 || SETTLE_US < 1) begin : g_bad_settle
         $error("settle time must be at least one cycle");
      end
      if (LOCK_TIMEOUT < 1) begin : g_bad_timeout
         $error("lock timeout must be at least one cycle");
      end
      if (NF_W < 2 || NR_W < 1 || NO_W < 1) begin : g_bad_width
         $error("divider widths too small");
      end
   endgenerate

   seq_state_t          st;
   logic [NR_W-1:0]     nr_q;
   logic [NF_W-1:0]     nf_q;
   logic [NO_W-1:0]     no_q;
   logic                legal;
   logic                tmr_clr;
   logic [TW-1:0]       tmr;
   logic                settle_end, wait_end;

   pll_param_check #(
      .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_KHZ(REF_KHZ)
   ) u_check (
      .nr(nr_in), .nf(nf_in), .no(no_in), .legal(legal)
   );

   assign settle_end = (st == SQ_SETTLE) && (tmr == TW'(SETTLE_CYC - 1));
   assign wait_end   = (st == SQ_POLL) && (tmr == TW'(LOCK_TIMEOUT - 1));
   assign tmr_clr    = (st == SQ_LOAD) || settle_end ||
                       (st == SQ_IDLE) || (st == SQ_HOLD);

   pll_seq_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .count(tmr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         mode_normal <= 1'b0;
         pll_rst     <= 1'b0;
         nr_field    <= '0;
         nf_field    <= '0;
         no_field    <= '0;
         bw_field    <= '0;
         nr_q        <= '0;
         nf_q        <= '0;
         no_q        <= '0;
         busy        <= 1'b0;
         done        <= 1'b0;
         err         <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (start) begin
                  if (legal) begin
                     nr_q        <= nr_in;
                     nf_q        <= nf_in;
                     no_q        <= no_in;
                     mode_normal <= 1'b0;
                     busy        <= 1'b1;
                     st          <= SQ_HOLD;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            SQ_HOLD: begin
               pll_rst <= 1'b1;
               st      <= SQ_LOAD;
            end
            SQ_LOAD: begin
               nr_field <= nr_q - NR_W'(1);
               nf_field <= nf_q - NF_W'(1);
               no_field <= no_q - NO_W'(1);
               bw_field <= nf_q[NF_W-1:1] - BW_W'(1);
               st       <= SQ_SETTLE;
            end
            SQ_SETTLE: begin
               if (settle_end) begin
                  pll_rst <= 1'b0;
                  st      <= SQ_POLL;
               end
            end
            SQ_POLL: begin
               if (lock_in) begin
                  mode_normal <= 1'b1;
                  done        <= 1'b1;
                  busy        <= 1'b0;
                  st          <= SQ_IDLE;
               end else if (wait_end) begin
                  err  <= 1'b1;
                  busy <= 1'b0;
                  st   <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
   parameter int NR_W       = 6,
   parameter int NF_W       = 13,
   parameter int NO_W       = 4,
   parameter int SETTLE_CYC = 2500
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lock_in,
   input logic            mode_normal,
   input logic            pll_rst,
   input logic [NR_W-1:0] nr_field,
   input logic [NF_W-1:0] nf_field,
   input logic [NO_W-1:0] no_field,
   input logic            busy,
   input logic            done,
   input logic            err
);
   localparam int CW = $clog2(SETTLE_CYC + 2) + 1;
   logic [CW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_cnt <= '0;
      else if (!pll_rst) hi_cnt <= '0;
      else if (hi_cnt != {CW{1'b1}}) hi_cnt <= hi_cnt + CW'(1);
   end

   AST_RST_ONLY_IN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst |-> !mode_normal); // R2
   AST_FIELDS_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({nr_field, nf_field, no_field}) |-> pll_rst); // R3
   AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_rst) |-> ($past(hi_cnt) >= CW'(SETTLE_CYC))); // R4
   AST_NORMAL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_normal) |-> ($past(lock_in) && done && !pll_rst)); // R5
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R10
   AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !busy); // R10
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
   .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .SETTLE_CYC(SETTLE_US * CYCLES_PER_US)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .mode_normal(mode_normal),
   .pll_rst(pll_rst), .nr_field(nr_field), .nf_field(nf_field),
   .no_field(no_field), .busy(busy), .done(done), .err(err)
);

// File: tb/tb_pll_reprog_seq.sv
`timescale 1ns/1ps
module tb_pll_reprog_seq;
   localparam int CPU      = 250;
   localparam int SUS      = 10;
   localparam int SETTLE   = CPU * SUS;
   localparam int LTO      = 4000;
   localparam int LOCK_DLY = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  nr_in = '0;
   logic [12:0] nf_in = '0;
   logic [3:0]  no_in = '0;
   logic        lock_in = 1'b0;
   logic        mode_normal, pll_rst, busy, done, err;
   logic [5:0]  nr_field;
   logic [12:0] nf_field;
   logic [3:0]  no_field;
   logic [11:0] bw_field;

   int n_tests = 0;
   int n_fail  = 0;
   bit lock_en = 1'b1;
   int lk_cnt  = 0;

   always #2 clk = ~clk;

   pll_reprog_seq #(
      .CYCLES_PER_US(CPU), .SETTLE_US(SUS), .LOCK_TIMEOUT(LTO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .nr_in(nr_in), .nf_in(nf_in),
      .no_in(no_in), .lock_in(lock_in), .mode_normal(mode_normal),
      .pll_rst(pll_rst), .nr_field(nr_field), .nf_field(nf_field),
      .no_field(no_field), .bw_field(bw_field), .busy(busy), .done(done),
      .err(err)
   );

   // synthesizer lock model: lock some cycles after reset release
   always @(posedge clk) begin
      if (!lock_en || pll_rst) begin
         lk_cnt  <= 0;
         lock_in <= 1'b0;
      end else if (lk_cnt == LOCK_DLY) begin
         lock_in <= 1'b1;
      end else begin
         lk_cnt <= lk_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input int nr, input int nf, input int no);
      @(negedge clk);
      start = 1'b1; nr_in = 6'(nr); nf_in = 13'(nf); no_in = 4'(no);
      @(negedge clk);
      start = 1'b0;
   endtask

   // full legal sequence with every step checked
   task automatic run_legal(input int nr, input int nf, input int no);
      int n;
      pulse_start(nr, nf, no);
      chk(busy == 1 && mode_normal == 0, "R2", "busy/slow after start", {busy, mode_normal}, 2);
      chk(pll_rst == 0, "R2", "reset not yet", pll_rst, 0);
      @(negedge clk);
      chk(pll_rst == 1 && mode_normal == 0, "R2", "reset after slow", pll_rst, 1);
      @(negedge clk);
      chk(nr_field == nr - 1, "R3", "nr field", nr_field, nr - 1);
      chk(nf_field == nf - 1, "R3", "nf field", nf_field, nf - 1);
      chk(no_field == no - 1, "R3", "no field", no_field, no - 1);
      chk(bw_field == nf / 2 - 1, "R3", "bw field", bw_field, nf / 2 - 1);
      n = 0;
      while (pll_rst && n < SETTLE + 10) begin @(negedge clk); n++; end
      chk(n == SETTLE, "R4", "settle cycles", n, SETTLE);
      n = 0;
      while (!done && n < LOCK_DLY + 20) begin
         chk(mode_normal == 0, "R5", "slow before lock", mode_normal, 0);
         @(negedge clk); n++;
      end
      chk(done == 1, "R5", "done seen", done, 1);
      chk(mode_normal == 1 && busy == 0 && err == 0, "R5", "normal/idle at done",
          {mode_normal, busy, err}, 4);
      chk(n == LOCK_DLY + 2, "R5", "lock to normal cycles", n, LOCK_DLY + 2);
      @(negedge clk);
      chk(done == 0, "R5", "done one cycle", done, 0);
   endtask

   task automatic run_illegal(input int nr, input int nf, input int no, input string why);
      logic        m0;
      logic [5:0]  f0;
      m0 = mode_normal; f0 = nr_field;
      pulse_start(nr, nf, no);
      chk(err == 1, "R6", why, err, 1);
      chk(mode_normal == m0 && pll_rst == 0 && busy == 0 && nr_field == f0,
          "R7", {"unchanged ", why}, {mode_normal, pll_rst, busy}, {m0, 2'b00});
      @(negedge clk);
      chk(err == 0 && pll_rst == 0, "R7", "err one cycle", err, 0);
   endtask

   // start during settle and start in the lock cycle are both ignored
   task automatic run_collide();
      int n;
      pulse_start(2, 100, 2);
      repeat (5) @(negedge clk);
      start = 1'b1; nr_in = 6'd1; nf_in = 13'd75; no_in = 4'd1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!lock_in && n < SETTLE + LOCK_DLY + 20) begin @(negedge clk); n++; end
      start = 1'b1; nr_in = 6'd1; nf_in = 13'd80; no_in = 4'd2;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1, "R8", "done in collision cycle", done, 1);
      @(negedge clk);
      chk(busy == 0 && done == 0, "R8", "start at lock ignored", busy, 0);
      @(negedge clk);
      chk(pll_rst == 0 && busy == 0, "R8", "no second reset", pll_rst, 0);
      chk(nf_field == 99 && nr_field == 1 && no_field == 1, "R8", "fields keep first triple",
          nf_field, 99);
   endtask

   task automatic run_timeout();
      int n;
      bit saw_done;
      lock_en = 1'b0;
      pulse_start(1, 50, 2);
      n = 0;
      while ((busy && !pll_rst) && n < 5) begin @(negedge clk); n++; end
      n = 0;
      while (pll_rst && n < SETTLE + 10) begin @(negedge clk); n++; end
      n = 0; saw_done = 0;
      while (!err && n < LTO + 20) begin
         if (done) saw_done = 1;
         @(negedge clk); n++;
      end
      chk(n == LTO, "R9", "timeout cycles", n, LTO);
      chk(err == 1 && busy == 0 && done == 0 && !saw_done, "R9", "err no done", err, 1);
      chk(mode_normal == 0, "R9", "stays slow", mode_normal, 0);
      @(negedge clk);
      chk(err == 0, "R9", "err one cycle", err, 0);
      lock_en = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(mode_normal == 0 && pll_rst == 0 && busy == 0 && done == 0 && err == 0,
          "R1", "reset controls", {mode_normal, pll_rst, busy, done, err}, 0);
      chk(nr_field == 0 && nf_field == 0 && no_field == 0 && bw_field == 0,
          "R1", "reset fields", nf_field, 0);
      rst_n = 1'b1;
      run_legal(1, 75, 1);
      run_illegal(1, 75, 3, "odd post divider");
      run_illegal(1, 18, 1, "vco below min");
      run_illegal(1, 92, 1, "vco above max");
      run_illegal(0, 75, 1, "zero reference divider");
      run_illegal(1, 75, 0, "zero post divider");
      run_legal(6, 110, 14);
      run_legal(1, 91, 1);
      run_collide();
      run_timeout();
      run_legal(9, 400, 2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule